// File: doc/BRIEF.md
# Hexadecimal Floating-Point Sequential Multiplier

This block multiplies two numbers held in the excess-64, base-16 floating-point format. A value is a sign bit (bit 31), a 7-bit exponent that counts powers of sixteen (bits 30:24) and a fraction of hex digits. The fraction is 24 bits in single precision (bits 23:0 of the high word) and 56 bits in double precision (those 24 bits followed by a 32-bit low word). The block returns the packed product, the low word in double precision, and three condition flags.

A request moves across a valid/ready handshake. When `in_ready` is high, the block takes the two operands, the precision select and the round-enable flag on the cycle where `in_valid` is also high. It stays busy with `in_ready` low until the result appears. Both operands are normalized on entry. The product exponent is range-checked before any multiplication, so operands that are certain to overflow or underflow finish early. Otherwise a right-shifting accumulator forms the fraction product one multiplier bit per clock: 24 steps, or 56 when the second operand has a nonzero low word. The product is then normalized one hex digit per clock, rounded in single precision if asked, and packed. The result side has no back-pressure. `res_valid` is high for exactly one cycle and the result outputs then hold until the next result, so a consumer must take the result in that cycle.

Top module: `hfp_mul_seq`

## Requirements
- R1: An operand whose leading fraction digits are zero is normalized (fraction shifted left by hex digits, exponent reduced by one per digit) before use, so its result equals that of the normalized encoding of the same value.
- R2: If either operand's fraction is entirely zero, the result is a clean zero (`res_hi` = 0, `res_lo` = 0, no flag), whatever its exponent or sign.
- R3: The product sign is the XOR of the operand signs, and the product exponent is the sum of the normalized exponents minus 64, less one for each hex digit of final normalization.
- R4: If the sum of normalized exponents minus 64 is below 0, the result is a clean zero with V only. If it is above 127, `res_hi` = {sign, 31 ones}, `res_lo` = all ones in double precision (0 in single), with V plus L (negative) or G (positive). Both are decided before any multiplication.
- R5: The fraction product is the 112-bit product of the two 56-bit fractions, truncated to its upper 56 bits. In double precision `res_lo` carries the low 32 of those bits.
- R6: If the exponent is negative after the product has been normalized, the result is a clean zero with V only.
- R7: In single precision with `rnd_en` set, 1 is added to the 24-bit fraction when the next lower product bit is 1. On a carry out of the fraction, the fraction is shifted right one hex digit and the exponent is raised, and an exponent above 127 then gives the overflow result of R4.
- R8: In double precision no rounding happens and `rnd_en` has no effect.
- R9: In single precision `a_lo` and `b_lo` are ignored and `res_lo` is 0.
- R10: A normal nonzero result raises exactly one of L (sign 1) or G (sign 0) and not V; L and G are never raised together.
- R11: `in_ready` is high only when the block is idle. A request transfers when `in_valid` and `in_ready` are both high, and `in_valid` while busy has no effect.
- R12: `res_valid` is high for exactly one cycle per accepted request, `in_ready` is high in that cycle, and the result outputs hold their value when `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| a_hi | input | 32 | First operand, sign/exponent/high fraction |
| a_lo | input | 32 | First operand, low fraction (double only) |
| b_hi | input | 32 | Second operand, sign/exponent/high fraction |
| b_lo | input | 32 | Second operand, low fraction (double only) |
| dbl | input | 1 | 1 selects double precision |
| rnd_en | input | 1 | 1 requests rounding (single precision only) |
| res_valid | output | 1 | One-cycle result strobe |
| res_hi | output | 32 | Packed product, high word |
| res_lo | output | 32 | Packed product, low word |
| flag_v | output | 1 | Exponent overflow or underflow |
| flag_l | output | 1 | Nonzero negative result or negative overflow |
| flag_g | output | 1 | Nonzero positive result or positive overflow |

## Verification
The final hex-digit normalization and the underflow decision act on the same product. A one-digit shift taken in the last normalization cycle can push an exponent of 0 to -1 just before packing. This is provoked with operand pairs whose exponents sum to exactly 64 and whose fractions multiply to a value with a leading zero digit, next to pairs that land one exponent higher. A sweep over exponents near both range limits, in both precisions and with and without rounding, is judged against an arithmetic model in the bench. A second overlap is a request held on `in_valid` while a multiplication is in progress. That request must not be taken, and the result must match the first operands alone.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  parameter int WORD_W  = 32;
  parameter int EXP_W   = 7;
  parameter int HFRAC_W = 24;
  localparam int FRAC_W   = HFRAC_W + WORD_W;
  localparam int ACC_W    = 2 * WORD_W;
  localparam int DIG_N    = FRAC_W / 4;
  localparam int LZ_W     = $clog2(DIG_N + 1);
  localparam int SEXP_W   = EXP_W + 3;
  localparam int EXP_MAX  = (1 << EXP_W) - 1;
  localparam int EXP_BIAS = 1 << (EXP_W - 1);
  localparam int CNT_W    = $clog2(FRAC_W + 1);

  typedef logic signed [SEXP_W-1:0] sexp_t;

  typedef struct packed {
    logic v;
    logic l;
    logic g;
  } hflags_t;

  typedef enum logic [1:0] {ST_IDLE, ST_MUL, ST_NORM, ST_PACK} hstate_t;
endpackage

// File: rtl/hfp_unpack.sv
module hfp_unpack
  import hfp_pkg::*;
(
  input  logic [WORD_W-1:0] w_hi,
  input  logic [WORD_W-1:0] w_lo,
  input  logic              dbl,
  output logic              sgn,
  output sexp_t             ex,
  output logic [FRAC_W-1:0] frac,
  output logic              zero
);
  logic [FRAC_W-1:0] raw;
  logic [LZ_W-1:0]   lz;
  logic              found;

  always_comb begin
    raw   = {w_hi[HFRAC_W-1:0], (dbl ? w_lo : {WORD_W{1'b0}})};
    lz    = '0;
    found = 1'b0;
    for (int i = DIG_N - 1; i >= 0; i--) begin
      if (!found) begin
        if (raw[4*i +: 4] != 4'h0) found = 1'b1;
        else lz = lz + LZ_W'(1);
      end
    end
    zero = !found;
    frac = raw << {lz, 2'b00};
    sgn  = found & w_hi[WORD_W-1];
    ex   = found ? (sexp_t'(w_hi[WORD_W-2 -: EXP_W]) - sexp_t'(lz)) : '0;
  end
endmodule

// File: rtl/hfp_shift_acc.sv
module hfp_shift_acc
  import hfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              step,
  input  logic              nstep,
  input  logic [FRAC_W-1:0] mcand_in,
  input  logic [FRAC_W-1:0] mplr_in,
  output logic [ACC_W-1:0]  acc
);
  logic [FRAC_W-1:0] mcand;
  logic [FRAC_W-1:0] mplr;
  logic [ACC_W:0]    sum;

  assign sum = {1'b0, acc} + (mplr[0] ? (ACC_W+1)'(mcand) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      mcand <= '0;
      mplr  <= '0;
    end else if (load) begin
      acc   <= '0;
      mcand <= mcand_in;
      mplr  <= mplr_in;
    end else if (step) begin
      acc   <= ACC_W'(sum >> 1);
      mplr  <= mplr >> 1;
    end else if (nstep) begin
      acc   <= acc << 4;
    end
  end
endmodule

// File: rtl/hfp_pack.sv
module hfp_pack
  import hfp_pkg::*;
(
  input  logic              early_zero,
  input  logic              early_under,
  input  logic              early_over,
  input  logic              sgn,
  input  logic              dbl,
  input  logic              rnd_en,
  input  sexp_t             ex,
  input  logic [FRAC_W-1:0] prod,
  output logic [WORD_W-1:0] hi,
  output logic [WORD_W-1:0] lo,
  output hflags_t           fl
);
  logic [HFRAC_W:0] h;
  sexp_t            e;
  logic             bump;

  always_comb begin
    h    = {1'b0, prod[FRAC_W-1 -: HFRAC_W]};
    e    = ex;
    bump = rnd_en & ~dbl & prod[WORD_W-1];
    h    = h + (HFRAC_W+1)'(bump);
    if (h[HFRAC_W]) begin
      h = h >> 4;
      e = e + sexp_t'(1);
    end
    hi = '0;
    lo = '0;
    fl = '0;
    if (early_zero) begin
      fl = '0;
    end else if (early_under || (ex < 0)) begin
      fl.v = 1'b1;
    end else if (early_over || (e > EXP_MAX)) begin
      hi   = {sgn, {(WORD_W-1){1'b1}}};
      lo   = dbl ? {WORD_W{1'b1}} : '0;
      fl.v = 1'b1;
      fl.l = sgn;
      fl.g = ~sgn;
    end else if (h != '0) begin
      hi   = {sgn, e[EXP_W-1:0], h[HFRAC_W-1:0]};
      lo   = dbl ? prod[WORD_W-1:0] : '0;
      fl.l = sgn;
      fl.g = ~sgn;
    end
  end
endmodule

// File: rtl/hfp_mul_seq.sv
module hfp_mul_seq
  import hfp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] a_hi,
  input  logic [WORD_W-1:0] a_lo,
  input  logic [WORD_W-1:0] b_hi,
  input  logic [WORD_W-1:0] b_lo,
  input  logic              dbl,
  input  logic              rnd_en,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_hi,
  output logic [WORD_W-1:0] res_lo,
  output logic              flag_v,
  output logic              flag_l,
  output logic              flag_g
);
  hstate_t           st;
  logic              sa, sb, za, zb;
  sexp_t             ea, eb, ex_sum;
  logic [FRAC_W-1:0] fa, fb, mplr_sel;
  logic              take, long_run, e_zero, e_under, e_over;
  logic              sgn_r, dbl_r, rnd_r, ez_r, eu_r, eo_r;
  sexp_t             ex_r;
  logic [CNT_W-1:0]  cnt;
  logic [ACC_W-1:0]  acc;
  logic              nstep;
  logic [WORD_W-1:0] pk_hi, pk_lo;
  hflags_t           pk_fl;

  hfp_unpack u_ua (.w_hi(a_hi), .w_lo(a_lo), .dbl(dbl), .sgn(sa), .ex(ea), .frac(fa), .zero(za));
  hfp_unpack u_ub (.w_hi(b_hi), .w_lo(b_lo), .dbl(dbl), .sgn(sb), .ex(eb), .frac(fb), .zero(zb));

  assign in_ready = (st == ST_IDLE);
  assign take     = in_valid & in_ready;
  assign ex_sum   = ea + eb - sexp_t'(EXP_BIAS);
  assign e_zero   = za | zb;
  assign e_under  = !e_zero && (ex_sum < 0);
  assign e_over   = !e_zero && (ex_sum > EXP_MAX);
  assign long_run = (fb[WORD_W-1:0] != '0);
  assign mplr_sel = long_run ? fb : (fb >> WORD_W);
  assign nstep    = (st == ST_NORM) && (acc[FRAC_W-1 -: 4] == 4'h0) && (acc != '0);

  hfp_shift_acc u_acc (
    .clk(clk), .rst_n(rst_n), .load(take), .step(st == ST_MUL), .nstep(nstep),
    .mcand_in(fa), .mplr_in(mplr_sel), .acc(acc)
  );

  hfp_pack u_pack (
    .early_zero(ez_r), .early_under(eu_r), .early_over(eo_r), .sgn(sgn_r),
    .dbl(dbl_r), .rnd_en(rnd_r), .ex(ex_r), .prod(acc[FRAC_W-1:0]),
    .hi(pk_hi), .lo(pk_lo), .fl(pk_fl)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      res_valid <= 1'b0;
      res_hi    <= '0;
      res_lo    <= '0;
      flag_v    <= 1'b0;
      flag_l    <= 1'b0;
      flag_g    <= 1'b0;
      sgn_r     <= 1'b0;
      dbl_r     <= 1'b0;
      rnd_r     <= 1'b0;
      ez_r      <= 1'b0;
      eu_r      <= 1'b0;
      eo_r      <= 1'b0;
      ex_r      <= '0;
      cnt       <= '0;
    end else begin
      res_valid <= 1'b0;
      case (st)
        ST_IDLE: if (take) begin
          sgn_r <= sa ^ sb;
          dbl_r <= dbl;
          rnd_r <= rnd_en;
          ez_r  <= e_zero;
          eu_r  <= e_under;
          eo_r  <= e_over;
          ex_r  <= ex_sum;
          cnt   <= long_run ? CNT_W'(FRAC_W) : CNT_W'(HFRAC_W);
          st    <= (e_zero || e_under || e_over) ? ST_PACK : ST_MUL;
        end
        ST_MUL: begin
          cnt <= cnt - CNT_W'(1);
          if (cnt == CNT_W'(1)) st <= ST_NORM;
        end
        ST_NORM: begin
          if (nstep) ex_r <= ex_r - sexp_t'(1);
          else       st   <= ST_PACK;
        end
        ST_PACK: begin
          res_hi    <= pk_hi;
          res_lo    <= pk_lo;
          flag_v    <= pk_fl.v;
          flag_l    <= pk_fl.l;
          flag_g    <= pk_fl.g;
          res_valid <= 1'b1;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/hfp_mul_chk.sv
module hfp_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        in_ready,
  input logic        res_valid,
  input logic [31:0] res_hi,
  input logic [31:0] res_lo,
  input logic        flag_v,
  input logic        flag_l,
  input logic        flag_g
);
  // R11
  busy_after_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);
  // R12
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);
  // R12
  ready_with_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> in_ready);
  // R12
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_hi) && $stable(res_lo)));
  // R10
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !(flag_l && flag_g));
  // R10
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !flag_v && (flag_l || flag_g)) |-> (flag_l == res_hi[31]));
  // R4
  ovf_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_v && (flag_l || flag_g)) |-> (res_hi[30:0] == 31'h7FFFFFFF));
  // R6
  unf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && flag_v && !flag_l && !flag_g) |-> (res_hi == 32'h0 && res_lo == 32'h0));
endmodule

bind hfp_mul_seq hfp_mul_chk chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo),
  .flag_v(flag_v), .flag_l(flag_l), .flag_g(flag_g)
);

// File: tb/hfp_mul_seq_tb.sv
`timescale 1ns/1ps
module hfp_mul_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] a_hi = '0, a_lo = '0, b_hi = '0, b_lo = '0;
  logic        dbl = 1'b0, rnd_en = 1'b0;
  logic        res_valid;
  logic [31:0] res_hi, res_lo;
  logic        flag_v, flag_l, flag_g;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  hfp_mul_seq dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .a_hi(a_hi), .a_lo(a_lo), .b_hi(b_hi), .b_lo(b_lo), .dbl(dbl), .rnd_en(rnd_en),
    .res_valid(res_valid), .res_hi(res_hi), .res_lo(res_lo),
    .flag_v(flag_v), .flag_l(flag_l), .flag_g(flag_g)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run did not finish, actual cycles=%0d expected<=150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  // Arithmetic reference: flags returned as {v,l,g}
  function automatic void model(input logic [31:0] ahi, alo, bhi, blo, input bit dp, rnd,
                                output logic [31:0] hi, lo, output logic [2:0] fl);
    logic [55:0]  fa, fb;
    logic [111:0] prod;
    logic [63:0]  p;
    logic [24:0]  h;
    int ea, eb, e;
    bit s;
    hi = '0; lo = '0; fl = '0;
    fa = {ahi[23:0], dp ? alo : 32'h0};
    fb = {bhi[23:0], dp ? blo : 32'h0};
    if (fa == 0 || fb == 0) return;
    ea = int'(ahi[30:24]);
    eb = int'(bhi[30:24]);
    while (fa[55:52] == 0) begin fa = fa << 4; ea = ea - 1; end
    while (fb[55:52] == 0) begin fb = fb << 4; eb = eb - 1; end
    s = ahi[31] ^ bhi[31];
    e = ea + eb - 64;
    if (e < 0) begin fl = 3'b100; return; end
    if (e > 127) begin
      hi = {s, 31'h7FFFFFFF}; lo = dp ? 32'hFFFFFFFF : 32'h0; fl = {1'b1, s, !s}; return;
    end
    prod = {56'h0, fa} * {56'h0, fb};
    p = 64'(prod >> 56);
    while (p[55:52] == 0) begin p = p << 4; e = e - 1; end
    if (e < 0) begin fl = 3'b100; return; end
    h = {1'b0, p[55:32]};
    if (!dp && rnd && p[31]) h = h + 25'd1;
    if (h[24]) begin h = h >> 4; e = e + 1; end
    if (e > 127) begin
      hi = {s, 31'h7FFFFFFF}; lo = dp ? 32'hFFFFFFFF : 32'h0; fl = {1'b1, s, !s}; return;
    end
    hi = {s, 7'(e), h[23:0]};
    lo = dp ? p[31:0] : 32'h0;
    fl = {1'b0, s, !s};
  endfunction

  task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  logic [31:0] g_hi, g_lo;
  logic [2:0]  g_fl;

  task automatic start_op(input logic [31:0] ahi, alo, bhi, blo, input bit dp, rnd);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    a_hi = ahi; a_lo = alo; b_hi = bhi; b_lo = blo; dbl = dp; rnd_en = rnd;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_res(input string tag);
    int n = 0;
    while (!res_valid && n < 300) begin @(negedge clk); n++; end
    if (!res_valid) begin
      n_fail = n_fail + 1;
      $display("FAIL %s timeout: actual res_valid=0 expected=1", tag);
    end
    g_hi = res_hi; g_lo = res_lo; g_fl = {flag_v, flag_l, flag_g};
  endtask

  task automatic run_chk(input string tag, input logic [31:0] ahi, alo, bhi, blo, input bit dp, rnd);
    logic [31:0] e_hi, e_lo;
    logic [2:0]  e_fl;
    model(ahi, alo, bhi, blo, dp, rnd, e_hi, e_lo, e_fl);
    start_op(ahi, alo, bhi, blo, dp, rnd);
    wait_res(tag);
    check(tag, "hi", g_hi, e_hi);
    check(tag, "lo", g_lo, e_lo);
    check(tag, "flags", {29'h0, g_fl}, {29'h0, e_fl});
  endtask

  task automatic run_fix(input string tag, input logic [31:0] ahi, alo, bhi, blo, input bit dp, rnd,
                         input logic [31:0] e_hi, e_lo, input logic [2:0] e_fl);
    start_op(ahi, alo, bhi, blo, dp, rnd);
    wait_res(tag);
    check(tag, "hi", g_hi, e_hi);
    check(tag, "lo", g_lo, e_lo);
    check(tag, "flags", {29'h0, g_fl}, {29'h0, e_fl});
  endtask

  function automatic logic [23:0] rand_frac();
    logic [23:0] f;
    f = 24'($urandom) | 24'h1;
    return f >> (4 * ($urandom % 3));
  endfunction

  initial begin
    logic [6:0] elist [7] = '{7'h00, 7'h01, 7'h20, 7'h40, 7'h41, 7'h60, 7'h7F};
    logic [31:0] h1, h2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12", "reset res_valid", {31'h0, res_valid}, 32'h0);
    check("R12", "reset res_hi", res_hi, 32'h0);
    check("R11", "reset in_ready", {31'h0, in_ready}, 32'h1);

    // R1 unnormalized operand equals its normalized encoding
    run_fix("R1", 32'h43000100, 32'h0, 32'h41100000, 32'h0, 1'b0, 1'b0, 32'h40100000, 32'h0, 3'b001);
    run_chk("R1", 32'h46000000, 32'h00000001, 32'h41300000, 32'h0, 1'b1, 1'b0);
    // R2 zero fraction beats a large exponent
    run_fix("R2", 32'h7F000000, 32'h0, 32'h7F100000, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 3'b000);
    run_fix("R2", 32'h41100000, 32'h0, 32'h80000000, 32'h0, 1'b1, 1'b1, 32'h0, 32'h0, 3'b000);
    // R3 / R10 signs and exponent
    run_fix("R3", 32'hC1100000, 32'h0, 32'h41100000, 32'h0, 1'b0, 1'b0, 32'hC1100000, 32'h0, 3'b010);
    run_fix("R10", 32'hC1100000, 32'h0, 32'hC1100000, 32'h0, 1'b0, 1'b0, 32'h41100000, 32'h0, 3'b001);
    // R4 early exponent range
    run_fix("R4", 32'h7F100000, 32'h0, 32'h7F100000, 32'h0, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h0, 3'b101);
    run_fix("R4", 32'hFF100000, 32'h0, 32'h7F100000, 32'h0, 1'b1, 1'b0, 32'hFFFFFFFF, 32'hFFFFFFFF, 3'b110);
    run_fix("R4", 32'h10100000, 32'h0, 32'h10100000, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 3'b100);
    // R6 underflow after normalization, and its neighbour one exponent higher
    run_fix("R6", 32'h20100000, 32'h0, 32'h20100000, 32'h0, 1'b0, 1'b0, 32'h0, 32'h0, 3'b100);
    run_fix("R6", 32'h21100000, 32'h0, 32'h20100000, 32'h0, 1'b0, 1'b0, 32'h00100000, 32'h0, 3'b001);
    // R7 rounding in single precision
    run_fix("R7", 32'h41800001, 32'h0, 32'h41800000, 32'h0, 1'b0, 1'b1, 32'h42400001, 32'h0, 3'b001);
    run_fix("R7", 32'h41800001, 32'h0, 32'h41800000, 32'h0, 1'b0, 1'b0, 32'h42400000, 32'h0, 3'b001);
    // R8 double precision ignores rnd_en; R5 low word kept
    run_fix("R8", 32'h41800001, 32'h0, 32'h41800000, 32'h0, 1'b1, 1'b1, 32'h42400000, 32'h80000000, 3'b001);
    run_chk("R5", 32'h41ABCDEF, 32'h12345678, 32'h42FEDCBA, 32'h9ABCDEF0, 1'b1, 1'b0);
    // R9 single precision ignores low words
    run_fix("R9", 32'h41800000, 32'hFFFFFFFF, 32'h41800000, 32'h12345678, 1'b0, 1'b1, 32'h42400000, 32'h0, 3'b001);

    // R11 request held while busy is not taken
    model(32'h41ABCDEF, 32'h11111111, 32'h41876543, 32'h22222222, 1'b1, 1'b0, h1, h2, g_fl);
    start_op(32'h41ABCDEF, 32'h11111111, 32'h41876543, 32'h22222222, 1'b1, 1'b0);
    a_hi = 32'h7F100000; b_hi = 32'h7F100000; dbl = 1'b0; in_valid = 1'b1;
    for (int k = 0; k < 10; k++) begin
      check("R11", "in_ready while busy", {31'h0, in_ready}, 32'h0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    wait_res("R11");
    check("R11", "hi after busy request", g_hi, h1);
    check("R11", "lo after busy request", g_lo, h2);
    // R12 pulse width and hold
    @(negedge clk);
    check("R12", "res_valid one cycle", {31'h0, res_valid}, 32'h0);
    repeat (4) @(negedge clk);
    check("R12", "res_hi held", res_hi, h1);
    check("R11", "in_ready idle", {31'h0, in_ready}, 32'h1);

    // Sweep over exponents, precision, rounding and fraction shapes
    for (int i = 0; i < 7; i++) begin
      for (int j = 0; j < 7; j++) begin
        for (int m = 0; m < 8; m++) begin
          logic [31:0] ah, al, bh, bl;
          ah = {1'($urandom), elist[i], rand_frac()};
          bh = {1'($urandom), elist[j], rand_frac()};
          al = m[2] ? $urandom : 32'h0;
          bl = m[2] ? $urandom : 32'h0;
          if (m[0]) run_chk("R5", ah, al, bh, bl, 1'b1, m[1]);
          else if (m[1]) run_chk("R7", ah, al, bh, bl, 1'b0, 1'b1);
          else run_chk("R3", ah, al, bh, bl, 1'b0, 1'b0);
        end
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule